// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block is the integer execution unit of a load-store processor core. Each cycle it takes a first operand, a second operand that the shifter stage has already prepared, the shifter's carry-out, the current status flags and a 4-bit operation code. It produces the 32-bit result with a register-write enable, and the next value of the four condition flags with a flag-write enable. Moves, bitwise logic, bit clear, addition and subtraction with and without carry, reverse subtraction and four flag-only compare and test operations are supported.

Every adder-based operation runs through one shared adder. Operand order, inversion of the second adder input and the carry-in are chosen per operation. Borrow follows the carry-flag convention: a carry of 1 after a subtraction means no borrow occurred, and the subtract-with-carry forms take away the inverse of the incoming carry flag. All outputs are registered, so results appear one clock after the inputs are presented.

Top module: `dp_alu`

## Requirements
- R1: Operation codes are 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The logic forms give rn&opnd, rn^opnd, rn|opnd, opnd, rn&~opnd and ~opnd.
- R2: ADD gives rn+opnd and ADC gives rn+opnd+C, both modulo 2^32. The carry flag is the carry out of bit 31.
- R3: SUB gives rn-opnd, SBC gives rn-opnd-(1-C), RSB gives opnd-rn and RSC gives opnd-rn-(1-C). The carry flag is 1 exactly when no borrow occurred.
- R4: For adder operations, V is 1 exactly when the true signed result lies outside the signed 32-bit range. Results wrap, so 0x7FFFFFFF+1 gives 0x80000000 with V=1.
- R5: TST, TEQ, CMP and CMN never assert result_we and always assert flags_we, whatever set_flags is. They set flags from rn&opnd, rn^opnd, rn-opnd and rn+opnd respectively.
- R6: When any other operation runs with set_flags low, flags_we is 0 and flags_out equals the flags_in that was presented.
- R7: For logic and move operations that update flags, C takes sh_carry and V keeps flags_in V.
- R8: Whenever flags update, N is result bit 31 and Z is 1 exactly when the 32-bit result is zero. Flag vectors are packed as {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R9: While rst is high at a clock edge, result, result_we, flags_out and flags_we all become zero.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge, which is a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Flag update request for non-compare operations |
| rn | input | 32 | First operand |
| opnd | input | 32 | Pre-shifted second operand |
| sh_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Registered result |
| result_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Registered next flags {N,Z,C,V} |
| flags_we | output | 1 | Flag register write enable |

## Verification
Every output is due exactly one clock after its inputs are applied. This holds for the result, both enables and the flags alike. The driver applies each vector on a falling edge and pushes the expected output into a queue. The monitor pops one entry a short delay after each following rising edge, which is the first moment that vector's registered output can be seen. Reset values are checked the same way, one edge after reset is held.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    logic     arith;
    logic     swap;
    logic     inv_b;
    cin_sel_e cin;
    logic     wr_rd;
    logic     cmp_only;
  } alu_ctrl_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  alu_op_e   op,
  output alu_ctrl_t ctrl
);

  always_comb begin
    ctrl = '{arith: 1'b0, swap: 1'b0, inv_b: 1'b0, cin: CIN_ZERO,
             wr_rd: 1'b1, cmp_only: 1'b0};
    unique case (op)
      OP_ADD, OP_CMN: begin
        ctrl.arith = 1'b1;
      end
      OP_ADC: begin
        ctrl.arith = 1'b1;
        ctrl.cin   = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        ctrl.arith = 1'b1;
        ctrl.inv_b = 1'b1;
        ctrl.cin   = CIN_ONE;
      end
      OP_SBC: begin
        ctrl.arith = 1'b1;
        ctrl.inv_b = 1'b1;
        ctrl.cin   = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl.arith = 1'b1;
        ctrl.swap  = 1'b1;
        ctrl.inv_b = 1'b1;
        ctrl.cin   = CIN_ONE;
      end
      OP_RSC: begin
        ctrl.arith = 1'b1;
        ctrl.swap  = 1'b1;
        ctrl.inv_b = 1'b1;
        ctrl.cin   = CIN_FLAG;
      end
      default: ;
    endcase
    if (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN}) begin
      ctrl.wr_rd    = 1'b0;
      ctrl.cmp_only = 1'b1;
    end
  end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] opnd,
  input  logic              swap,
  input  logic              inv_b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] a_in;
  logic [DATA_W-1:0] b_in;
  logic [SUM_W-1:0]  total;

  always_comb begin
    a_in  = swap ? opnd : rn;
    b_in  = swap ? rn : opnd;
    b_in  = inv_b ? ~b_in : b_in;
    total = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin};
    sum   = total[DATA_W-1:0];
    cout  = total[DATA_W];
    ovf   = (a_in[DATA_W-1] == b_in[DATA_W-1]) &&
            (total[DATA_W-1] != a_in[DATA_W-1]);
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] lres
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: lres = rn & opnd;
      OP_EOR, OP_TEQ: lres = rn ^ opnd;
      OP_ORR:         lres = rn | opnd;
      OP_MOV:         lres = opnd;
      OP_BIC:         lres = rn & ~opnd;
      OP_MVN:         lres = ~opnd;
      default:        lres = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] opnd,
  input  logic              sh_carry,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [3:0]        flags_out,
  output logic              flags_we
);

  alu_op_e           op_e;
  alu_ctrl_t         ctrl;
  logic              add_cin;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              ovf;
  logic [DATA_W-1:0] lres;
  logic [DATA_W-1:0] res_nx;
  logic              upd_nx;
  logic [3:0]        flags_nx;

  assign op_e = alu_op_e'(op);

  dp_alu_decode u_dec (
    .op   (op_e),
    .ctrl (ctrl)
  );

  always_comb begin
    unique case (ctrl.cin)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flags_in[FLAG_C];
      default:  add_cin = 1'b0;
    endcase
  end

  dp_alu_adder #(.DATA_W(DATA_W)) u_add (
    .rn    (rn),
    .opnd  (opnd),
    .swap  (ctrl.swap),
    .inv_b (ctrl.inv_b),
    .cin   (add_cin),
    .sum   (sum),
    .cout  (cout),
    .ovf   (ovf)
  );

  dp_alu_logic #(.DATA_W(DATA_W)) u_log (
    .op   (op_e),
    .rn   (rn),
    .opnd (opnd),
    .lres (lres)
  );

  always_comb begin
    res_nx = ctrl.arith ? sum : lres;
    upd_nx = ctrl.cmp_only | set_flags;
    if (upd_nx) begin
      flags_nx[FLAG_N] = res_nx[DATA_W-1];
      flags_nx[FLAG_Z] = (res_nx == '0);
      flags_nx[FLAG_C] = ctrl.arith ? cout : sh_carry;
      flags_nx[FLAG_V] = ctrl.arith ? ovf : flags_in[FLAG_V];
    end else begin
      flags_nx = flags_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= '0;
      flags_we  <= 1'b0;
    end else begin
      result    <= res_nx;
      result_we <= ctrl.wr_rd;
      flags_out <= flags_nx;
      flags_we  <= upd_nx;
    end
  end

  // primed is high when the previous edge saw rst low
  logic primed;
  always_ff @(posedge clk) primed <= !rst;

  // R5: compare and test forms update flags only
  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op) inside {4'd8, 4'd9, 4'd10, 4'd11})
      |-> (!result_we && flags_we));

  // R6: flags pass through untouched without an update request
  p_hold_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(set_flags) && !($past(op) inside {4'd8, 4'd9, 4'd10, 4'd11}))
      |-> (!flags_we && flags_out == $past(flags_in)));

  // R7: logic forms take C from the shifter and keep V
  p_logic_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(set_flags) &&
     $past(op) inside {4'd0, 4'd1, 4'd12, 4'd13, 4'd14, 4'd15})
      |-> (flags_out[FLAG_C] == $past(sh_carry) &&
           flags_out[FLAG_V] == $past(flags_in[FLAG_V])));

  // R8: N and Z follow the registered result whenever flags are written
  p_nz_track_r8: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[FLAG_N] == result[DATA_W-1] &&
                  flags_out[FLAG_Z] == (result == '0)));

  // R10: register write enable follows the previous cycle's operation class
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (primed && !($past(op) inside {4'd8, 4'd9, 4'd10, 4'd11})) |-> result_we);

endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic        set_flags = 1'b0;
  logic [31:0] rn = '0;
  logic [31:0] opnd = '0;
  logic        sh_carry = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;
  logic        flags_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [37:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;

  dp_alu uut (
    .clk(clk), .rst(rst), .op(op), .set_flags(set_flags), .rn(rn),
    .opnd(opnd), .sh_carry(sh_carry), .flags_in(flags_in),
    .result(result), .result_we(result_we), .flags_out(flags_out),
    .flags_we(flags_we)
  );

  // reference model: packs {result_we, flags_we, {N,Z,C,V}, result}
  function automatic logic [37:0] model(input logic [3:0] o, input logic s,
      input logic [31:0] a, input logic [31:0] b, input logic shc,
      input logic [3:0] fin);
    logic [31:0] r;
    logic c, v, arith, cmp, upd, bw;
    logic [32:0] full;
    longint sv;
    logic [3:0] f;
    arith = 1'b0; c = shc; v = fin[0]; r = '0;
    cmp = (o >= 4'd8 && o <= 4'd11);
    bw  = ~fin[1];
    case (o)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      4'd4, 4'd11, 4'd5: begin
        arith = 1'b1;
        full = {1'b0, a} + {1'b0, b} + ((o == 4'd5) ? {32'd0, fin[1]} : 33'd0);
        r = full[31:0]; c = full[32];
        sv = longint'($signed(a)) + longint'($signed(b)) + ((o == 4'd5) ? longint'(fin[1]) : 0);
        v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      default: begin
        logic [31:0] x, y;
        logic br;
        arith = 1'b1;
        x  = (o == 4'd3 || o == 4'd7) ? b : a;
        y  = (o == 4'd3 || o == 4'd7) ? a : b;
        br = (o == 4'd6 || o == 4'd7) ? bw : 1'b0;
        r  = x - y - {31'd0, br};
        c  = ({32'd0, x} >= ({32'd0, y} + {63'd0, br}));
        sv = longint'($signed(x)) - longint'($signed(y)) - longint'(br);
        v  = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
    endcase
    upd = cmp | s;
    if (upd) f = {r[31], (r == 32'd0), c, v};
    else     f = fin;
    if (!arith && upd) f[0] = fin[0];
    return {~cmp, upd, f, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic s);
    if (o >= 4'd8 && o <= 4'd11) return "R5";
    if (!s) return "R6";
    if (o == 4'd0 || o == 4'd1 || o >= 4'd12) return "R7";
    if (o == 4'd2 || o == 4'd3 || o == 4'd6 || o == 4'd7) return "R3";
    return "R2";
  endfunction

  task automatic apply(input logic [3:0] o, input logic s, input logic [31:0] a,
      input logic [31:0] b, input logic shc, input logic [3:0] fin, input string tg);
    item_t it;
    @(negedge clk);
    op = o; set_flags = s; rn = a; opnd = b; sh_carry = shc; flags_in = fin;
    it.exp = model(o, s, a, b, shc, fin);
    it.tag = tg;
    sb.push_back(it);
  endtask

  // monitor: R10, each vector's output is due right after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [37:0] got;
        it  = sb.pop_front();
        got = {result_we, flags_we, flags_out, result};
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s R10 op=%0d: got we=%b fwe=%b f=%b res=%h, expected we=%b fwe=%b f=%b res=%h",
                   it.tag, op, got[37], got[36], got[35:32], got[31:0],
                   it.exp[37], it.exp[36], it.exp[35:32], it.exp[31:0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== '0 || result_we !== 1'b0 || flags_out !== '0 || flags_we !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: got res=%h we=%b f=%b fwe=%b, expected all zero",
               result, result_we, flags_out, flags_we);
    end
    rst = 1'b0;
    // R1 logic forms
    apply(4'd0,  1'b0, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 4'b0000, "R1");
    apply(4'd1,  1'b0, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 4'b1010, "R1");
    apply(4'd12, 1'b0, 32'h0000_00F0, 32'h0F00_000F, 1'b0, 4'b0101, "R1");
    apply(4'd13, 1'b0, 32'h1234_5678, 32'hDEAD_BEEF, 1'b1, 4'b0000, "R1");
    apply(4'd14, 1'b0, 32'hFFFF_FFFF, 32'h0000_FF00, 1'b0, 4'b0000, "R1");
    apply(4'd15, 1'b0, 32'h0,         32'h0000_0001, 1'b0, 4'b0000, "R1");
    // R2 add forms
    apply(4'd4,  1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'b0000, "R2");
    apply(4'd5,  1'b1, 32'h0000_0010, 32'h0000_0020, 1'b0, 4'b0010, "R2");
    apply(4'd5,  1'b1, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 4'b0010, "R2");
    // R4 overflow and wrap
    apply(4'd4,  1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'b0000, "R4");
    apply(4'd2,  1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'b0000, "R4");
    apply(4'd3,  1'b1, 32'h0000_0001, 32'h8000_0000, 1'b0, 4'b0000, "R4");
    // R3 subtract forms, carry is no-borrow
    apply(4'd2,  1'b1, 32'h0000_0005, 32'h0000_0005, 1'b0, 4'b0000, "R3");
    apply(4'd2,  1'b1, 32'h0000_0003, 32'h0000_0005, 1'b0, 4'b0000, "R3");
    apply(4'd6,  1'b1, 32'h0000_0010, 32'h0000_0004, 1'b0, 4'b0000, "R3");
    apply(4'd6,  1'b1, 32'h0000_0010, 32'h0000_0004, 1'b0, 4'b0010, "R3");
    apply(4'd3,  1'b1, 32'h0000_0004, 32'h0000_0010, 1'b0, 4'b0000, "R3");
    apply(4'd7,  1'b1, 32'h0000_0004, 32'h0000_0010, 1'b0, 4'b0000, "R3");
    apply(4'd7,  1'b1, 32'h0000_0010, 32'h0000_0010, 1'b0, 4'b0000, "R3");
    // R5 compare forms with set_flags low
    apply(4'd10, 1'b0, 32'h0000_0007, 32'h0000_0007, 1'b0, 4'b0000, "R5");
    apply(4'd11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'b0001, "R5");
    apply(4'd8,  1'b0, 32'hF000_0000, 32'h0F00_0000, 1'b1, 4'b0001, "R5");
    apply(4'd9,  1'b0, 32'h8000_0001, 32'h0000_0001, 1'b0, 4'b0100, "R5");
    // R6 no update request
    apply(4'd4,  1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 4'b1011, "R6");
    apply(4'd13, 1'b0, 32'h0,         32'h0,         1'b1, 4'b0110, "R6");
    // R7 and R8 logic with update
    apply(4'd13, 1'b1, 32'h0,         32'h0,         1'b1, 4'b0001, "R8");
    apply(4'd0,  1'b1, 32'h8000_0000, 32'hC000_0000, 1'b0, 4'b0011, "R7");
    apply(4'd15, 1'b1, 32'h0,         32'hFFFF_FFFF, 1'b1, 4'b1100, "R8");
    // sweep across all codes
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [3:0] o;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (i % 7 == 0) ? a : lfsr;
      o = 4'(i % 16);
      apply(o, lfsr[3], a, b, lfsr[5], lfsr[11:8], tag_of(o, lfsr[3]));
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule